// File: doc/BRIEF.md
# Striped Matrix Block Store

This block holds an N×N matrix of fixed-point words in K parallel RAM banks. Column c of every row goes to bank c mod K. The K neighbouring elements of a row that form one aligned block all sit at one shared bank address. A whole K-wide row block can therefore be read or written in a single access. A factorisation engine uses the block as its working store. It asks for a target row block, a pivot row block, an off-diagonal scalar or a diagonal scalar by giving (i, j, k) indices. The block forms the bank address with shifts and concatenation only.

Every read passes through three register stages:
- address generation;
- the bank read;
- lane selection and output.

So data appears on the output exactly three cycles after the request is taken. Reads return either the whole K-lane block or one element that has been picked from its bank by the low column bits. The block keeps the most recent pivot block on a separate output. An engine can then read the pivot once per sweep and still use the single read path for target rows.

The matrix is filled through a load port, one word per cycle, in row-major order. A block write port updates chosen lanes of one row block. When the load port and the block write port are active in the same cycle, the load wins.

Top module: `matblk_mem`

## Requirements
- R1: While rst_ni is low, rd_valid_o is 0 and piv_data_o is all zeros.
- R2: The load port fills the matrix in row-major order. After reset, the m-th word accepted with load_valid_i high, counting from 0, is element A[m/N, m mod N]. After N*N words the count wraps back to element A[0,0].
- R3: A read with kind code 0 (target row) returns the block A[j, kb..kb+K-1], where kb is k with its low log2(K) bits cleared. Column kb+l appears in rd_data_o[l*DW +: DW].
- R4: A read with kind code 1 (pivot) returns the block A[i, kb..kb+K-1] in the same lane layout as R3. The same block is captured into piv_data_o, which then holds it until the next pivot read completes. Reads of any other kind leave piv_data_o unchanged.
- R5: A read with kind code 2 (scalar) returns A[j,i] in rd_data_o[DW-1:0], with all higher bits zero.
- R6: A read with kind code 3 (diagonal) returns A[i,i] in rd_data_o[DW-1:0], with all higher bits zero.
- R7: Take a request sampled at a rising edge with rd_valid_i high. rd_valid_o and its data appear after the third following rising edge, for exactly one cycle per request. Back-to-back requests give back-to-back results, and rd_valid_o stays low otherwise.
- R8: A block write addresses row wr_row_i, column block wr_cblk_i. It updates only the lanes whose bit in wr_lane_en_i is set. Lane l carries column wr_cblk_i*K+l from wr_data_i[l*DW +: DW]. All other lanes keep their contents.
- R9: A read issued in the same cycle as a write to the same block returns the old contents. A read issued one cycle later returns the new contents.
- R10: When load_valid_i and wr_valid_i are high in the same cycle, the load word is stored and the block write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_valid_i | input | 1 | Load word present |
| load_data_i | input | DW | Load word, row-major order |
| rd_valid_i | input | 1 | Read request |
| rd_kind_i | input | 2 | 0 target row, 1 pivot row, 2 scalar A[j,i], 3 diagonal A[i,i] |
| idx_i_i | input | log2(N) | Pivot index i |
| idx_j_i | input | log2(N) | Target row index j |
| idx_k_i | input | log2(N) | Column index k of the block |
| wr_valid_i | input | 1 | Block write request |
| wr_row_i | input | log2(N) | Row of block write |
| wr_cblk_i | input | log2(N/K) | Column block of block write |
| wr_lane_en_i | input | K | Per-lane write enable |
| wr_data_i | input | K*DW | Block write data, lane l at [l*DW +: DW] |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | K*DW | Read block, or scalar in the low lane |
| piv_data_o | output | K*DW | Last pivot block read |

## Verification
The matrix is loaded with values that are distinct for every row and column. A block read from the wrong row, from the wrong column block or with its lanes rotated therefore gives a value that can be told apart from the right one. Target and pivot reads use k values that are not aligned to a block, which shows that the low column bits are dropped from the block address. Scalar reads use columns that land in lanes other than 0 and the last lane, which tests the lane picking and the zero fill above it. A write with a sparse lane mask separates per-lane enables from whole-block writes. A write issued together with a read, and then a second read one cycle later, distinguishes old-data from new-data behaviour on a collision. A load word sent together with a block write shows whether the load really takes priority.

// File: rtl/matblk_pkg.sv
package matblk_pkg;
  typedef enum logic [1:0] {
    RD_ROW    = 2'd0,
    RD_PIVOT  = 2'd1,
    RD_SCALAR = 2'd2,
    RD_DIAG   = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/matblk_addr.sv
// Block address = {row, column block}: equals (row << log2(N/K)) | (col >> log2(K)).
module matblk_addr #(
  parameter int N = 16,
  parameter int K = 4,
  localparam int IW = $clog2(N),
  localparam int CBW = $clog2(N / K),
  localparam int AW = IW + CBW
) (
  input  logic [IW-1:0]  row_i,
  input  logic [CBW-1:0] cblk_i,
  output logic [AW-1:0]  addr_o
);
  assign addr_o = {row_i, cblk_i};
endmodule

// File: rtl/matblk_bank.sv
// One lane bank: registered read, old data on same-address write.
module matblk_bank #(
  parameter int DW = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/matblk_out.sv
// Output stage: lane pick for scalar kinds, pivot capture.
module matblk_out
  import matblk_pkg::*;
#(
  parameter int K = 4,
  parameter int DW = 16,
  localparam int LKW = $clog2(K),
  localparam int BW = K * DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  rd_kind_e       kind_i,
  input  logic [LKW-1:0] lane_i,
  input  logic [BW-1:0]  blk_i,
  output logic           valid_o,
  output logic [BW-1:0]  data_o,
  output logic [BW-1:0]  piv_o
);
  logic [DW-1:0] elem;
  logic          scalar;

  assign elem   = blk_i[lane_i*DW +: DW];
  assign scalar = (kind_i == RD_SCALAR) || (kind_i == RD_DIAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      piv_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= scalar ? BW'(elem) : blk_i;
      if (valid_i && kind_i == RD_PIVOT) piv_o <= blk_i;
    end
  end
endmodule

// File: rtl/matblk_mem.sv
module matblk_mem
  import matblk_pkg::*;
#(
  parameter int N = 16,
  parameter int K = 4,
  parameter int DW = 16,
  localparam int IW = $clog2(N),
  localparam int LKW = $clog2(K),
  localparam int CBW = $clog2(N / K),
  localparam int AW = IW + CBW,
  localparam int DEPTH = N * N / K,
  localparam int LW = 2 * IW,
  localparam int BW = K * DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_valid_i,
  input  logic [DW-1:0]  load_data_i,
  input  logic           rd_valid_i,
  input  logic [1:0]     rd_kind_i,
  input  logic [IW-1:0]  idx_i_i,
  input  logic [IW-1:0]  idx_j_i,
  input  logic [IW-1:0]  idx_k_i,
  input  logic           wr_valid_i,
  input  logic [IW-1:0]  wr_row_i,
  input  logic [CBW-1:0] wr_cblk_i,
  input  logic [K-1:0]   wr_lane_en_i,
  input  logic [BW-1:0]  wr_data_i,
  output logic           rd_valid_o,
  output logic [BW-1:0]  rd_data_o,
  output logic [BW-1:0]  piv_data_o
);
  rd_kind_e      kind;
  logic [IW-1:0] rd_row, rd_col;
  logic [AW-1:0] rd_addr, wr_addr;

  // load counter: low bits pick the bank, high bits the address
  logic [LW-1:0] ld_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ld_cnt_q <= '0;
    else if (load_valid_i) ld_cnt_q <= ld_cnt_q + 1'b1;
  end

  always_comb begin
    kind   = rd_kind_e'(rd_kind_i);
    rd_row = (kind == RD_ROW || kind == RD_SCALAR) ? idx_j_i : idx_i_i;
    rd_col = (kind == RD_ROW || kind == RD_PIVOT)  ? idx_k_i : idx_i_i;
  end

  matblk_addr #(.N(N), .K(K)) u_rd_addr (
    .row_i (rd_row),
    .cblk_i(rd_col[IW-1:LKW]),
    .addr_o(rd_addr)
  );

  matblk_addr #(.N(N), .K(K)) u_wr_addr (
    .row_i (wr_row_i),
    .cblk_i(wr_cblk_i),
    .addr_o(wr_addr)
  );

  // write source select: load has priority
  logic [K-1:0]  w_en;
  logic [AW-1:0] w_addr;
  logic [BW-1:0] w_data;
  always_comb begin
    w_en   = '0;
    w_addr = wr_addr;
    w_data = wr_data_i;
    if (load_valid_i) begin
      w_en   = K'(1) << ld_cnt_q[LKW-1:0];
      w_addr = ld_cnt_q[LW-1:LKW];
      w_data = {K{load_data_i}};
    end else if (wr_valid_i) begin
      w_en = wr_lane_en_i;
    end
  end

  // stage 1: address generation register
  logic           s1_re_q;
  rd_kind_e       s1_kind_q;
  logic [LKW-1:0] s1_lane_q;
  logic [AW-1:0]  s1_raddr_q, s1_waddr_q;
  logic [K-1:0]   s1_we_q;
  logic [BW-1:0]  s1_wdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_re_q    <= 1'b0;
      s1_kind_q  <= RD_ROW;
      s1_lane_q  <= '0;
      s1_raddr_q <= '0;
      s1_waddr_q <= '0;
      s1_we_q    <= '0;
      s1_wdata_q <= '0;
    end else begin
      s1_re_q    <= rd_valid_i;
      s1_kind_q  <= kind;
      s1_lane_q  <= rd_col[LKW-1:0];
      s1_raddr_q <= rd_addr;
      s1_waddr_q <= w_addr;
      s1_we_q    <= w_en;
      s1_wdata_q <= w_data;
    end
  end

  // stage 2: bank access
  logic [BW-1:0] bank_rdata;
  for (genvar l = 0; l < K; l++) begin : g_bank
    matblk_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk_i  (clk_i),
      .we_i   (s1_we_q[l]),
      .waddr_i(s1_waddr_q),
      .wdata_i(s1_wdata_q[l*DW +: DW]),
      .re_i   (s1_re_q),
      .raddr_i(s1_raddr_q),
      .rdata_o(bank_rdata[l*DW +: DW])
    );
  end

  logic           s2_valid_q;
  rd_kind_e       s2_kind_q;
  logic [LKW-1:0] s2_lane_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid_q <= 1'b0;
      s2_kind_q  <= RD_ROW;
      s2_lane_q  <= '0;
    end else begin
      s2_valid_q <= s1_re_q;
      s2_kind_q  <= s1_kind_q;
      s2_lane_q  <= s1_lane_q;
    end
  end

  // stage 3: output
  matblk_out #(.K(K), .DW(DW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s2_valid_q),
    .kind_i (s2_kind_q),
    .lane_i (s2_lane_q),
    .blk_i  (bank_rdata),
    .valid_o(rd_valid_o),
    .data_o (rd_data_o),
    .piv_o  (piv_data_o)
  );
endmodule

// File: rtl/matblk_mem_chk.sv
module matblk_mem_chk #(
  parameter int K = 4,
  parameter int DW = 16,
  localparam int BW = K * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_valid_i,
  input logic [1:0]    rd_kind_i,
  input logic          rd_valid_o,
  input logic [BW-1:0] rd_data_o,
  input logic [BW-1:0] piv_data_o
);
  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_IDLE: assert (!rd_valid_o && piv_data_o == '0); // R1

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> ##3 rd_valid_o); // R7

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |-> ##3 !rd_valid_o); // R7

  AST_PIVOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(piv_data_o) |-> ($past(rd_valid_i, 3) && $past(rd_kind_i, 3) == 2'd1)); // R4

  AST_SCALAR_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_kind_i[1]) |-> ##3 (rd_data_o[BW-1:DW] == '0)); // R5
endmodule

bind matblk_mem matblk_mem_chk #(.K(K), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_valid_i(rd_valid_i),
  .rd_kind_i (rd_kind_i),
  .rd_valid_o(rd_valid_o),
  .rd_data_o (rd_data_o),
  .piv_data_o(piv_data_o)
);

// File: tb/matblk_mem_test.sv
`timescale 1ns/1ps
module matblk_mem_test;
  localparam int N = 16, K = 4, DW = 16;
  localparam int IW = $clog2(N), CBW = $clog2(N / K), BW = K * DW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic load_valid = 1'b0, rd_valid = 1'b0, wr_valid = 1'b0;
  logic [DW-1:0] load_data = '0;
  logic [1:0] rd_kind = '0;
  logic [IW-1:0] idx_i = '0, idx_j = '0, idx_k = '0, wr_row = '0;
  logic [CBW-1:0] wr_cblk = '0;
  logic [K-1:0] wr_lane_en = '0;
  logic [BW-1:0] wr_data = '0;
  logic rd_valid_o;
  logic [BW-1:0] rd_data_o, piv_data_o;

  logic [DW-1:0] mdl [N][N];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  matblk_mem #(.N(N), .K(K), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .load_valid_i(load_valid), .load_data_i(load_data),
    .rd_valid_i(rd_valid), .rd_kind_i(rd_kind),
    .idx_i_i(idx_i), .idx_j_i(idx_j), .idx_k_i(idx_k),
    .wr_valid_i(wr_valid), .wr_row_i(wr_row), .wr_cblk_i(wr_cblk),
    .wr_lane_en_i(wr_lane_en), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .piv_data_o(piv_data_o)
  );

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] val(int r, int c, int seed);
    return DW'(r * 97 + c * 13 + seed * 7 + 1);
  endfunction

  function automatic logic [BW-1:0] blk(int r, int k);
    logic [BW-1:0] b;
    int kb = (k / K) * K;
    for (int l = 0; l < K; l++) b[l*DW +: DW] = mdl[r][kb + l];
    return b;
  endfunction

  task automatic load_all(input int seed);
    for (int m = 0; m < N * N; m++) begin
      @(negedge clk);
      load_valid = 1'b1;
      load_data  = val(m / N, m % N, seed);
      mdl[m / N][m % N] = load_data;
    end
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  // issue one read, check R7 timing, return data
  task automatic do_read(input logic [1:0] kind, input int i, input int j, input int k,
                         output logic [BW-1:0] data);
    @(negedge clk);
    rd_valid = 1'b1; rd_kind = kind;
    idx_i = IW'(i); idx_j = IW'(j); idx_k = IW'(k);
    @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
    check("R7 valid early", BW'(rd_valid_o), BW'(0));
    @(negedge clk);
    check("R7 valid on time", BW'(rd_valid_o), BW'(1));
    data = rd_data_o;
  endtask

  task automatic t_reset;
    check("R1 rd_valid_o in reset", BW'(rd_valid_o), BW'(0));
    check("R1 piv_data_o in reset", piv_data_o, '0);
  endtask

  task automatic t_load_and_rows;
    logic [BW-1:0] d;
    load_all(0);
    do_read(2'd0, 0, 0, 0, d);   check("R2 R3 row 0 block 0", d, blk(0, 0));
    do_read(2'd0, 0, 15, 14, d); check("R2 R3 row 15 last block", d, blk(15, 14));
    do_read(2'd0, 9, 7, 6, d);   check("R3 unaligned k", d, blk(7, 6));
  endtask

  task automatic t_pivot;
    logic [BW-1:0] d;
    do_read(2'd1, 3, 12, 9, d);
    check("R4 pivot data", d, blk(3, 9));
    check("R4 pivot latch", piv_data_o, blk(3, 9));
    do_read(2'd0, 3, 12, 9, d);
    check("R4 row read target", d, blk(12, 9));
    check("R4 latch held", piv_data_o, blk(3, 9));
  endtask

  task automatic t_scalar;
    logic [BW-1:0] d;
    do_read(2'd2, 6, 5, 0, d);  check("R5 scalar A[5,6]", d, BW'(mdl[5][6]));
    do_read(2'd2, 13, 2, 0, d); check("R5 scalar A[2,13]", d, BW'(mdl[2][13]));
    do_read(2'd3, 15, 0, 0, d); check("R6 diag A[15,15]", d, BW'(mdl[15][15]));
    do_read(2'd3, 10, 4, 4, d); check("R6 diag A[10,10]", d, BW'(mdl[10][10]));
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    rd_valid = 1'b1; rd_kind = 2'd0; idx_j = 4'd1; idx_k = 4'd0;
    @(negedge clk);
    idx_j = 4'd2; idx_k = 4'd4;
    @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
    check("R7 first of pair", {rd_valid_o ? rd_data_o : '0}, blk(1, 0));
    @(negedge clk);
    check("R7 second of pair", {rd_valid_o ? rd_data_o : '0}, blk(2, 4));
    @(negedge clk);
    check("R7 valid drops", BW'(rd_valid_o), BW'(0));
  endtask

  task automatic t_lane_write;
    logic [BW-1:0] d;
    @(negedge clk);
    wr_valid = 1'b1; wr_row = 4'd2; wr_cblk = 2'd1; wr_lane_en = 4'b1010;
    for (int l = 0; l < K; l++) wr_data[l*DW +: DW] = DW'(16'hA0A0 + l);
    @(negedge clk);
    wr_valid = 1'b0;
    mdl[2][5] = 16'hA0A1;
    mdl[2][7] = 16'hA0A3;
    do_read(2'd0, 0, 2, 4, d);
    check("R8 sparse lane write", d, blk(2, 4));
  endtask

  task automatic t_collision;
    logic [BW-1:0] old_b;
    old_b = blk(3, 0);
    @(negedge clk);
    wr_valid = 1'b1; wr_row = 4'd3; wr_cblk = 2'd0; wr_lane_en = '1;
    for (int l = 0; l < K; l++) wr_data[l*DW +: DW] = DW'(16'h5500 + l);
    rd_valid = 1'b1; rd_kind = 2'd0; idx_j = 4'd3; idx_k = 4'd0;
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    rd_valid = 1'b0;
    for (int l = 0; l < K; l++) mdl[3][l] = DW'(16'h5500 + l);
    @(negedge clk);
    check("R9 same-cycle read old", rd_data_o, old_b);
    @(negedge clk);
    check("R9 next-cycle read new", rd_data_o, blk(3, 0));
  endtask

  task automatic t_load_priority;
    logic [BW-1:0] d;
    // load counter has wrapped: next word is A[0,0]
    @(negedge clk);
    load_valid = 1'b1; load_data = 16'hBEEF;
    wr_valid = 1'b1; wr_row = 4'd1; wr_cblk = 2'd0; wr_lane_en = '1; wr_data = {K{16'h1234}};
    @(negedge clk);
    load_valid = 1'b0; wr_valid = 1'b0;
    mdl[0][0] = 16'hBEEF;
    do_read(2'd0, 0, 1, 0, d); check("R10 block write discarded", d, blk(1, 0));
    do_read(2'd3, 0, 0, 0, d); check("R2 R10 wrapped load stored", d, BW'(16'hBEEF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_load_and_rows();
    t_pivot();
    t_scalar();
    t_back_to_back();
    t_lane_write();
    t_collision();
    t_load_priority();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule